// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a countdown timer with a loadable start value, a power-of-two prescaler and a choice between one-shot and periodic operation. Software-facing logic writes three registers through a simple write port: the start value, the prescale setting and the timer entry. The timer entry holds an 8-bit vector, a mask bit and a mode bit. A combinational read port returns any of those registers or the live count. The count advances only on cycles where the base clock-enable input is high, and only after the prescaler has collected its full share of those ticks.

When the count steps from 1 to 0, the block raises a one-cycle interrupt strobe and puts the vector from the timer entry on its vector output. A masked entry suppresses the strobe and leaves counting unchanged. In periodic mode, the first count step after 0 reloads the start value, so the count follows start − (elapsed mod (start+1)). In one-shot mode the count holds at 0.

The control is a three-state machine. IDLE means no count is running. RUN means the count is above zero. EXPIRED means the count is at zero with a nonzero start value. The transitions are:
- any state → IDLE on a start-value write of 0.
- any state → RUN on a nonzero start-value write.
- RUN → EXPIRED on the count step from 1 to 0; this transition fires the strobe.
- EXPIRED → RUN on a count step while the mode bit selects periodic.
- EXPIRED → EXPIRED on a count step in one-shot mode.

Top module: `interval_timer`

## Requirements
- R1: After reset, the count, the strobe, the vector output and all three registers read 0, and the machine is in IDLE.
- R2: A write to the prescale register keeps only bits 0, 1 and 3 (mask 0xB). A write to the timer entry keeps only bits 7:0 (vector), bit 16 (mask) and bit 17 (periodic), which is mask 0x300FF.
- R3: The prescale code is {bit3, bit1, bit0}, and the shift is (code+1) mod 8. The count advances once every 2^shift enabled base ticks, so code 7 (register value 0xB) advances on every tick.
- R4: A start-value write loads that value into the count at the writing edge and clears the prescaler phase.
- R5: In one-shot mode (entry bit 17 = 0), the count decrements to 0 and then stays at 0.
- R6: In periodic mode (entry bit 17 = 1), the count step that follows a count of 0 reloads the start value.
- R7: The strobe is high for exactly the one cycle in which the count first reads 0 after a step from 1. In that cycle the vector output equals entry bits 7:0.
- R8: While entry bit 16 is set, an expiry raises no strobe and leaves the vector output unchanged. Counting goes on exactly as it would with the bit clear.
- R9: A start value of 0 stops the timer: the count stays 0 and no strobe is raised.
- R10: A timer-entry write neither resets the count nor the prescaler phase. A new mode bit applies from the next count step, so an expired one-shot count switched to periodic reloads on that step.
- R11: On cycles with the base tick input low, the prescaler and the count do not change.
- R12: Read select 0, 1, 2 and 3 return, in the same cycle, the start value, the prescale register, the timer entry and the live count.
- R13: A start-value write on the same edge as a count step wins: the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base clock-enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start value, 1 prescale, 2 timer entry, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select: 0 start, 1 prescale, 2 entry, 3 live count |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| cur_count | output | 32 | Live count |
| irq_strobe | output | 1 | One-cycle expiry strobe |
| irq_vector | output | 8 | Vector of the last unmasked expiry |

## Verification
Register writes, including a start-value load, show up right after the writing edge. A count step shows up right after the edge on which the 2^shift-th enabled tick since the last step or load lands. The expiry strobe and its vector appear in the same cycle that the count first reads 0. Read data follows the select with no clock at all. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge from the same inputs the design sees. It compares every output on the next falling edge, so each result is checked in exactly the cycle it is due. Explicit checks wait a counted number of falling edges that follows from these latencies.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int SEL_W        = 2;
    localparam int DIV_W        = 4;
    localparam int SHIFT_W      = 3;
    localparam int VEC_W        = 8;
    localparam int MASK_POS     = 16;
    localparam int PERIODIC_POS = 17;

    localparam logic [SEL_W-1:0] SEL_START = 2'd0;
    localparam logic [SEL_W-1:0] SEL_DIV   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_ENTRY = 2'd2;
    localparam logic [SEL_W-1:0] SEL_LIVE  = 2'd3;

    localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;

    // Scattered 3-bit code: bit 3 supplies the top code bit.
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] div);
        logic [SHIFT_W-1:0] code;
        code = {div[3], div[1:0]};
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic [CNT_W-1:0]    live_count,
    output logic [CNT_W-1:0]    start_q,
    output logic [DIV_W-1:0]    div_q,
    output logic [CNT_W-1:0]    entry_q,
    output logic                load,
    output logic [SHIFT_W-1:0]  shift,
    output logic [CNT_W-1:0]    rd_data
);

    localparam logic [CNT_W-1:0] ENTRY_KEEP = CNT_W'((64'd1 << PERIODIC_POS)
                                                   | (64'd1 << MASK_POS)
                                                   | ((64'd1 << VEC_W) - 64'd1));

    assign load  = wr_en && (wr_sel == SEL_START);
    assign shift = div_to_shift(div_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            div_q   <= '0;
            entry_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_START: start_q <= wr_data;
                SEL_DIV:   div_q   <= wr_data[DIV_W-1:0] & DIV_KEEP;
                SEL_ENTRY: entry_q <= wr_data & ENTRY_KEEP;
                default:   start_q <= start_q;
            endcase
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_START: rd_data = start_q;
            SEL_DIV:   rd_data = {{(CNT_W-DIV_W){1'b0}}, div_q};
            SEL_ENTRY: rd_data = entry_q;
            default:   rd_data = live_count;
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               step
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    // Last phase value before a step; ">=" absorbs a shrinking shift.
    assign limit = (PRE_W'(1) << shift) - PRE_W'(1);
    assign step  = tick && (phase_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || step) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/tmr_count_fsm.sv
`timescale 1ns/1ps
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  start_q,
    input  logic              step,
    input  logic              periodic,
    input  logic              masked,
    input  logic [VEC_W-1:0]  vec_in,
    output logic [CNT_W-1:0]  count_q,
    output logic              irq_q,
    output logic [VEC_W-1:0]  vec_q
);

    tmr_state_e       st_q, st_n;
    logic [CNT_W-1:0] count_n;
    logic             fire;

    always_comb begin
        st_n    = st_q;
        count_n = count_q;
        fire    = 1'b0;
        if (load) begin
            count_n = load_val;
            st_n    = (load_val == '0) ? ST_IDLE : ST_RUN;
        end else if (step) begin
            unique case (st_q)
                ST_IDLE: begin
                    st_n = ST_IDLE;
                end
                ST_RUN: begin
                    if (count_q == CNT_W'(1)) begin
                        count_n = '0;
                        fire    = 1'b1;
                        st_n    = ST_EXPIRED;
                    end else begin
                        count_n = count_q - CNT_W'(1);
                    end
                end
                ST_EXPIRED: begin
                    if (periodic) begin
                        count_n = start_q;
                        st_n    = ST_RUN;
                    end
                end
                default: begin
                    st_n = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            count_q <= count_n;
            irq_q   <= fire && !masked;
            if (fire && !masked) vec_q <= vec_in;
        end
    end

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  cur_count,
    output logic              irq_strobe,
    output logic [7:0]        irq_vector
);

    localparam int PRE_W = 1 << SHIFT_W;

    logic [CNT_W-1:0]   start_q;
    logic [DIV_W-1:0]   div_q;
    logic [CNT_W-1:0]   entry_q;
    logic               load;
    logic               step;
    logic [SHIFT_W-1:0] shift;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .live_count (cur_count),
        .start_q    (start_q),
        .div_q      (div_q),
        .entry_q    (entry_q),
        .load       (load),
        .shift      (shift),
        .rd_data    (rd_data)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .restart (load),
        .shift   (shift),
        .step    (step)
    );

    tmr_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data),
        .start_q  (start_q),
        .step     (step),
        .periodic (entry_q[PERIODIC_POS]),
        .masked   (entry_q[MASK_POS]),
        .vec_in   (entry_q[VEC_W-1:0]),
        .count_q  (cur_count),
        .irq_q    (irq_strobe),
        .vec_q    (irq_vector)
    );

endmodule

// File: rtl/interval_timer_chk.sv
`timescale 1ns/1ps
module interval_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             load,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cur_count,
    input logic             irq_strobe,
    input logic [CNT_W-1:0] start_q,
    input logic [CNT_W-1:0] entry_q,
    input logic             step
);

    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_count == $past(wr_data));

    a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !entry_q[17] && !load) |=> cur_count == '0);

    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur_count == '0 && entry_q[17] && start_q != '0 && !load)
            |=> cur_count == $past(start_q));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |=> !irq_strobe);

    a_r7_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> cur_count == '0);

    a_r8_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> !$past(entry_q[16]));

    a_r9_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr_data == '0) |=> (cur_count == '0 && !irq_strobe));

    a_r11_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(cur_count));

endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .load       (load),
    .wr_data    (wr_data),
    .cur_count  (cur_count),
    .irq_strobe (irq_strobe),
    .start_q    (start_q),
    .entry_q    (entry_q),
    .step       (step)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en = 1'b1;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic [31:0] cur_count;
    logic        irq_strobe;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int tick_mode = 0;
    bit done = 0;
    string phase = "R1";
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    logic [31:0] m_start, m_entry, m_cnt;
    logic [3:0]  m_div;
    int          m_pre, m_shift;
    bit          m_live, m_irq, m_step;
    logic [7:0]  m_vec;

    interval_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cur_count(cur_count), .irq_strobe(irq_strobe), .irq_vector(irq_vector)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? 1'b0 : lfsr[0];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_entry = 0; m_cnt = 0; m_div = 0;
            m_pre = 0; m_live = 0; m_irq = 0; m_vec = 0;
        end else begin
            m_shift = ((m_div[3] * 4 + m_div[1:0]) + 1) % 8;
            m_step  = tick_en && (m_pre >= (1 << m_shift) - 1);
            m_irq   = 0;
            if (wr_en && wr_sel == 2'd0) begin
                m_cnt  = wr_data;
                m_live = (wr_data != 0);
                m_pre  = 0;
            end else begin
                if (m_live && m_step) begin
                    if (m_cnt > 1) m_cnt = m_cnt - 1;
                    else if (m_cnt == 1) begin
                        m_cnt = 0;
                        if (!m_entry[16]) begin m_irq = 1; m_vec = m_entry[7:0]; end
                    end else if (m_entry[17]) m_cnt = m_start;
                end
                if (m_step) m_pre = 0;
                else if (tick_en) m_pre = m_pre + 1;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_start = wr_data;
                    2'd1: m_div   = wr_data[3:0] & 4'hB;
                    2'd2: m_entry = wr_data & 32'h0003_00FF;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] rexp;
            case (rd_sel)
                2'd0: rexp = m_start;
                2'd1: rexp = {28'd0, m_div};
                2'd2: rexp = m_entry;
                default: rexp = m_cnt;
            endcase
            chk(cur_count == m_cnt, phase, cur_count, m_cnt);
            chk(irq_strobe == m_irq, phase, irq_strobe, m_irq);
            chk(irq_vector == m_vec, phase, irq_vector, m_vec);
            chk(rd_data == rexp, "R12", rd_data, rexp);
            if (irq_strobe) irq_seen++;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] sel, input logic [31:0] exp, input string req);
        rd_sel = sel;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
        rd_sel = 2'd3;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; rd_sel = 2'd3;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 4; s++) rd_expect(2'(s), 32'd0, "R1");
        chk(cur_count == 0, "R1", cur_count, 0);
        chk(irq_strobe == 0, "R1", irq_strobe, 0);
        chk(irq_vector == 0, "R1", irq_vector, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 write masking
        phase = "R2";
        wr(2'd1, 32'hFFFF_FFFF); rd_expect(2'd1, 32'hB, "R2");
        wr(2'd2, 32'hFFFF_FFFF); rd_expect(2'd2, 32'h0003_00FF, "R2");

        // R3/R5/R7 divide by 1, one-shot
        phase = "R5";
        wr(2'd1, 32'hB); wr(2'd2, 32'h41); wr(2'd0, 32'd5);
        chk(cur_count == 5, "R4", cur_count, 5);
        rd_expect(2'd0, 32'd5, "R12");
        repeat (4) @(negedge clk);
        chk(cur_count == 1, "R3", cur_count, 1);
        @(negedge clk);
        chk(cur_count == 0 && irq_strobe, "R7", {cur_count[7:0], 7'd0, irq_strobe}, 1);
        chk(irq_vector == 8'h41, "R7", irq_vector, 8'h41);
        @(negedge clk);
        chk(!irq_strobe, "R7", irq_strobe, 0);
        repeat (3) @(negedge clk);
        chk(cur_count == 0, "R5", cur_count, 0);

        // R3 divide by 4 (code 1)
        phase = "R3";
        wr(2'd1, 32'h1); wr(2'd0, 32'd3);
        repeat (11) @(negedge clk);
        chk(cur_count == 1, "R3", cur_count, 1);
        @(negedge clk);
        chk(cur_count == 0 && irq_strobe, "R3", cur_count, 0);
        // bit 3 gives code 4: divide by 32
        wr(2'd1, 32'h8); wr(2'd0, 32'd2);
        repeat (63) @(negedge clk);
        chk(cur_count == 1, "R3", cur_count, 1);
        @(negedge clk);
        chk(cur_count == 0, "R3", cur_count, 0);
        // bit 2 dropped: code 0, divide by 2
        wr(2'd1, 32'h4); rd_expect(2'd1, 32'h0, "R2");
        wr(2'd0, 32'd2);
        repeat (3) @(negedge clk);
        chk(cur_count == 1, "R3", cur_count, 1);
        @(negedge clk);
        chk(cur_count == 0, "R3", cur_count, 0);

        // R6 periodic reload
        phase = "R6";
        wr(2'd1, 32'hB); wr(2'd2, 32'h0002_0033); wr(2'd0, 32'd3);
        repeat (3) @(negedge clk);
        chk(cur_count == 0 && irq_strobe, "R6", cur_count, 0);
        chk(irq_vector == 8'h33, "R7", irq_vector, 8'h33);
        @(negedge clk);
        chk(cur_count == 3, "R6", cur_count, 3);
        repeat (3) @(negedge clk);
        chk(irq_strobe == 1, "R6", irq_strobe, 1);

        // R8 masked entry
        phase = "R8";
        wr(2'd2, 32'h0003_0055);
        @(negedge clk); irq_seen = 0;
        repeat (20) @(negedge clk);
        chk(irq_seen == 0, "R8", irq_seen, 0);
        chk(irq_vector == 8'h33, "R8", irq_vector, 8'h33);

        // R10 mode change without restart
        phase = "R10";
        wr(2'd2, 32'h0002_0066); wr(2'd1, 32'h0); wr(2'd0, 32'd6);
        repeat (3) @(negedge clk);
        wr(2'd2, 32'h0000_0066);
        for (int i = 0; i < 40 && cur_count != 0; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(cur_count == 0, "R10", cur_count, 0);
        wr(2'd2, 32'h0002_0066);
        repeat (4) @(negedge clk);
        chk(cur_count == 6 || cur_count == 5, "R10", cur_count, 6);

        // R11 no ticks, then irregular ticks
        phase = "R11";
        tick_mode = 1;
        repeat (2) @(negedge clk);
        c = cur_count;
        repeat (10) @(negedge clk);
        chk(cur_count == c, "R11", cur_count, c);
        wr(2'd1, 32'hB); wr(2'd2, 32'h0002_0077); wr(2'd0, 32'd7);
        tick_mode = 2;
        repeat (300) @(negedge clk);
        tick_mode = 0;
        repeat (2) @(negedge clk);

        // R13 load beats a coincident step
        phase = "R13";
        wr(2'd0, 32'd9);
        repeat (2) @(negedge clk);
        wr(2'd0, 32'd6);
        chk(cur_count == 6, "R13", cur_count, 6);
        @(negedge clk);
        chk(cur_count == 5, "R13", cur_count, 5);

        // R4 load clears prescaler phase
        phase = "R4";
        wr(2'd1, 32'h0); wr(2'd0, 32'd5);
        @(negedge clk);
        wr(2'd0, 32'd5);
        chk(cur_count == 5, "R4", cur_count, 5);
        @(negedge clk);
        chk(cur_count == 5, "R4", cur_count, 5);
        @(negedge clk);
        chk(cur_count == 4, "R4", cur_count, 4);

        // R9 zero start value
        phase = "R9";
        wr(2'd0, 32'd0);
        chk(cur_count == 0, "R9", cur_count, 0);
        irq_seen = 0;
        repeat (30) @(negedge clk);
        chk(irq_seen == 0, "R9", irq_seen, 0);
        chk(cur_count == 0, "R9", cur_count, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule